// File: doc/BRIEF.md
# DDR2 Off-Chip-Driver Calibration Mode Handler

This block is the device-side controller for the output-driver calibration sequence of a DDR2 memory die. It looks at each decoded command and the three-bit calibration selector that comes with an extended-mode-register write. From these it moves between idle, a drive session and an adjust session. In a drive session it turns on the data and strobe output drivers at fixed levels a set number of cycles after the enter command. It turns them off the same number of cycles after the exit command. The memory controller uses this to measure the driver impedance.

In an adjust session the block waits for the write latency, which is additive latency plus CAS latency minus one. It then samples four serial beats of the adjust code in a fixed order and presents the result for one cycle to the impedance-step register. A recovery window must then pass before an exit is honoured. Misused commands are flagged on two one-cycle error pulses.

Top module: `ocd_cal_handler`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle: `dq_oe`, `dqs_oe`, `adj_valid`, `cmd_err` and `bl_err` are low after that edge.
- R2: In idle, `cmd`=2'b01 with `ocd_sel`=3'b001 starts drive-high. `dq_oe` and `dqs_oe` stay low until the T_OIT-th rising edge after the command edge and are high after it. At that point every `dq_level` bit is 1, `dqs_t`=1 and `dqs_c`=0.
- R3: In idle, `cmd`=2'b01 with `ocd_sel`=3'b100 starts drive-low with the same timing. Every `dq_level` bit is 0, `dqs_t`=0 and `dqs_c`=1.
- R4: In a drive session, `cmd`=2'b01 with `ocd_sel`=3'b000 (exit) is accepted. The enables stay high until the T_OIT-th rising edge after the exit edge and are low after it.
- R5: In idle with `bl4` high, `cmd`=2'b01 with `ocd_sel`=3'b010 starts adjust. With WL = `al`+`cl`-1 (at least 1), `adj_bit` is sampled at rising edges WL, WL+1, WL+2 and WL+3 after the command edge as beats 0 to 3. After the beat-3 edge, `adj_code[i]` equals beat i and `adj_valid` is high for exactly one cycle.
- R6: An adjust command in idle with `bl4` low raises `bl_err` for the one cycle after the command edge. No capture is made and the block stays idle.
- R7: In an adjust session, an exit command sampled fewer than T_WR edges after the beat-3 edge raises `cmd_err` and is ignored. An exit sampled T_WR or more edges after it returns the block to idle without an error.
- R8: In a drive or adjust session, any command other than NOP (`cmd`=2'b00) or an accepted exit raises `cmd_err` for one cycle and is ignored. Output enables, levels and an ongoing capture are unaffected.
- R9: The capture point follows `al` and `cl`: the shortest latency (WL=1) and longer settings each place beat 0 at edge WL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 2 | Decoded command: 00 NOP, 01 extended-mode write, 10/11 any other command |
| ocd_sel | input | 3 | Calibration selector with an extended-mode write: 000 exit, 001 drive-high, 100 drive-low, 010 adjust |
| al | input | LAT_W | Additive latency in cycles |
| cl | input | LAT_W | CAS latency in cycles |
| bl4 | input | 1 | High when burst length 4 is programmed |
| adj_bit | input | 1 | Adjust data beat sampled per cycle |
| dq_oe | output | 1 | Data output enable |
| dq_level | output | DQ_W | Forced data levels |
| dqs_oe | output | 1 | Strobe output enable |
| dqs_t | output | 1 | True strobe level |
| dqs_c | output | 1 | Complement strobe level |
| adj_code | output | 4 | Captured adjust code, bit i = beat i |
| adj_valid | output | 1 | One-cycle pulse when `adj_code` is new |
| bl_err | output | 1 | Adjust rejected for wrong burst length |
| cmd_err | output | 1 | Illegal or early command in a session |

## Verification
Two functions can meet in one cycle: the final beat of the adjust capture and the flagging of a stray command. The bench places a non-NOP command in the very cycle whose rising edge samples beat 3. It then expects the complete code with `adj_valid` and a `cmd_err` pulse after that edge. A second meeting point is the recovery window closing at the same time an exit arrives. The bench sends one exit an edge early, which must be flagged. It sends the next exit exactly on the boundary, which must be accepted. Acceptance is shown when a following drive command turns the drivers on.

// File: rtl/ocd_cal_pkg.sv
// Shared encodings for the driver calibration handler.
// Assumes commands arrive already decoded into a two-bit class.
package ocd_cal_pkg;

    localparam logic [1:0] CMD_NOP  = 2'b00;
    localparam logic [1:0] CMD_EMRS = 2'b01;

    localparam logic [2:0] SEL_EXIT   = 3'b000;
    localparam logic [2:0] SEL_DRV_HI = 3'b001;
    localparam logic [2:0] SEL_ADJUST = 3'b010;
    localparam logic [2:0] SEL_DRV_LO = 3'b100;

    typedef enum logic [2:0] {
        OP_NOP, OP_EXIT, OP_DRV_HI, OP_DRV_LO, OP_ADJUST, OP_OTHER
    } op_e;

    typedef enum logic [1:0] {
        MODE_IDLE, MODE_DRIVE, MODE_ADJUST
    } mode_e;

    typedef enum logic [1:0] {
        PH_OFF, PH_WAIT, PH_BEAT, PH_REST
    } phase_e;

endpackage

// File: rtl/ocd_cmd_decode.sv
// Classifies one command slot into a calibration operation.
// Assumes: purely combinational; non-calibration selector values count as OTHER.
module ocd_cmd_decode
    import ocd_cal_pkg::*;
(
    input  logic [1:0] cmd,
    input  logic [2:0] sel,
    output op_e        op
);

    // Map command class and selector to one operation.
    always_comb begin
        op = OP_OTHER;
        if (cmd == CMD_NOP) begin
            op = OP_NOP;
        end else if (cmd == CMD_EMRS) begin
            case (sel)
                SEL_EXIT:   op = OP_EXIT;
                SEL_DRV_HI: op = OP_DRV_HI;
                SEL_DRV_LO: op = OP_DRV_LO;
                SEL_ADJUST: op = OP_ADJUST;
                default:    op = OP_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/ocd_mode_fsm.sv
// Session state machine: idle, drive or adjust; raises the error pulses.
// Assumes: adj_done from the capture unit marks the end of the recovery window.
module ocd_mode_fsm
    import ocd_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic bl4,
    input  logic adj_done,
    output logic drv_on,
    output logic drv_off,
    output logic drv_hi,
    output logic adj_start,
    output logic adj_stop,
    output logic cmd_err,
    output logic bl_err
);

    mode_e mode_q, mode_d;
    logic  cmd_err_q, cmd_err_d;
    logic  bl_err_q, bl_err_d;

    // Next-mode and strobe decisions for the current command.
    always_comb begin
        mode_d    = mode_q;
        drv_on    = 1'b0;
        drv_off   = 1'b0;
        drv_hi    = 1'b0;
        adj_start = 1'b0;
        adj_stop  = 1'b0;
        cmd_err_d = 1'b0;
        bl_err_d  = 1'b0;
        case (mode_q)
            MODE_IDLE: begin
                if (op == OP_DRV_HI || op == OP_DRV_LO) begin
                    drv_on = 1'b1;
                    drv_hi = (op == OP_DRV_HI);
                    mode_d = MODE_DRIVE;
                end else if (op == OP_ADJUST) begin
                    if (bl4) begin
                        adj_start = 1'b1;
                        mode_d    = MODE_ADJUST;
                    end else begin
                        bl_err_d = 1'b1;
                    end
                end
            end
            MODE_DRIVE: begin
                if (op == OP_EXIT) begin
                    drv_off = 1'b1;
                    mode_d  = MODE_IDLE;
                end else if (op != OP_NOP) begin
                    cmd_err_d = 1'b1;
                end
            end
            MODE_ADJUST: begin
                if (op == OP_EXIT && adj_done) begin
                    adj_stop = 1'b1;
                    mode_d   = MODE_IDLE;
                end else if (op != OP_NOP) begin
                    cmd_err_d = 1'b1;
                end
            end
            default: mode_d = MODE_IDLE;
        endcase
    end

    // Mode and error-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_IDLE;
            cmd_err_q <= 1'b0;
            bl_err_q  <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            cmd_err_q <= cmd_err_d;
            bl_err_q  <= bl_err_d;
        end
    end

    assign cmd_err = cmd_err_q;
    assign bl_err  = bl_err_q;

    assert_err_in_session_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_q |-> ($past(mode_q) != MODE_IDLE));

    assert_bl_reject_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bl_err_q |-> (mode_q == MODE_IDLE && !$past(bl4)));

    assert_exit_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ADJUST && op == OP_EXIT && !adj_done) |=> (mode_q == MODE_ADJUST));

endmodule

// File: rtl/ocd_drive_ctrl.sv
// Turns the output drivers on or off a fixed T_OIT cycles after a request.
// Assumes: T_OIT >= 1; the level is applied together with the enable.
module ocd_drive_ctrl #(
    parameter int T_OIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_on,
    input  logic go_off,
    input  logic want_hi,
    output logic oe,
    output logic lvl
);

    localparam int OIT_W = $clog2(T_OIT + 1);

    logic [OIT_W-1:0] cnt_q;
    logic             tgt_q;
    logic             pend_q;
    logic             oe_q;
    logic             lvl_q;

    // Delay counter; the pending target lands when it reaches its last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tgt_q  <= 1'b0;
            pend_q <= 1'b0;
            oe_q   <= 1'b0;
            lvl_q  <= 1'b0;
        end else if (go_on) begin
            cnt_q  <= OIT_W'(T_OIT);
            tgt_q  <= 1'b1;
            pend_q <= want_hi;
        end else if (go_off) begin
            cnt_q <= OIT_W'(T_OIT);
            tgt_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == OIT_W'(1)) begin
                oe_q <= tgt_q;
                if (tgt_q) lvl_q <= pend_q;
            end
        end
    end

    assign oe  = oe_q;
    assign lvl = lvl_q;

    assert_oe_on_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> ($past(cnt_q) == OIT_W'(1)));

endmodule

// File: rtl/ocd_adjust_capture.sv
// Waits the write latency, shifts in four adjust beats, then times recovery.
// Assumes: wl >= 1 and T_WR >= 1; beats are never reordered by burst mode.
module ocd_adjust_capture
    import ocd_cal_pkg::*;
#(
    parameter int WL_W = 4,
    parameter int T_WR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic [WL_W-1:0] wl,
    input  logic            adj_bit,
    output logic [3:0]      code,
    output logic            valid,
    output logic            done
);

    localparam int TWR_W = $clog2(T_WR + 1);
    localparam int CNT_W = (WL_W > TWR_W) ? WL_W : TWR_W;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       beat_q;
    logic [2:0]       shreg_q;
    logic [3:0]       code_q;
    logic             valid_q;

    // Phase sequencing, beat capture and recovery countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            beat_q  <= '0;
            shreg_q <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                phase_q <= PH_WAIT;
                cnt_q   <= CNT_W'(wl);
            end else if (stop) begin
                phase_q <= PH_OFF;
            end else begin
                case (phase_q)
                    PH_WAIT: begin
                        if (cnt_q == CNT_W'(1)) begin
                            shreg_q[0] <= adj_bit;
                            beat_q     <= 2'd1;
                            phase_q    <= PH_BEAT;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_BEAT: begin
                        if (beat_q == 2'd3) begin
                            code_q  <= {adj_bit, shreg_q};
                            valid_q <= 1'b1;
                            cnt_q   <= CNT_W'(T_WR - 1);
                            phase_q <= PH_REST;
                        end else begin
                            shreg_q[beat_q] <= adj_bit;
                            beat_q          <= beat_q + 1'b1;
                        end
                    end
                    PH_REST: begin
                        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign code  = code_q;
    assign valid = valid_q;
    assign done  = (phase_q == PH_REST) && (cnt_q == '0);

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    assert_valid_after_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ($past(phase_q) == PH_BEAT && phase_q == PH_REST));

endmodule

// File: rtl/ocd_cal_handler.sv
// Top of the driver calibration handler: decode, session control,
// driver timing and adjust-code capture.
// Assumes: al + cl >= 2, so the write latency is at least one cycle.
module ocd_cal_handler
    import ocd_cal_pkg::*;
#(
    parameter int DQ_W  = 8,
    parameter int LAT_W = 3,
    parameter int T_OIT = 4,
    parameter int T_WR  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd,
    input  logic [2:0]       ocd_sel,
    input  logic [LAT_W-1:0] al,
    input  logic [LAT_W-1:0] cl,
    input  logic             bl4,
    input  logic             adj_bit,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  dq_level,
    output logic             dqs_oe,
    output logic             dqs_t,
    output logic             dqs_c,
    output logic [3:0]       adj_code,
    output logic             adj_valid,
    output logic             bl_err,
    output logic             cmd_err
);

    localparam int WL_W = LAT_W + 1;

    op_e             op;
    logic            drv_on, drv_off, drv_hi;
    logic            adj_start, adj_stop, adj_done;
    logic            oe, lvl;
    logic [WL_W-1:0] wl;

    // Write latency is one less than read latency.
    assign wl = {1'b0, al} + {1'b0, cl} - WL_W'(1);

    ocd_cmd_decode u_dec (
        .cmd (cmd),
        .sel (ocd_sel),
        .op  (op)
    );

    ocd_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .bl4       (bl4),
        .adj_done  (adj_done),
        .drv_on    (drv_on),
        .drv_off   (drv_off),
        .drv_hi    (drv_hi),
        .adj_start (adj_start),
        .adj_stop  (adj_stop),
        .cmd_err   (cmd_err),
        .bl_err    (bl_err)
    );

    ocd_drive_ctrl #(.T_OIT(T_OIT)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_on   (drv_on),
        .go_off  (drv_off),
        .want_hi (drv_hi),
        .oe      (oe),
        .lvl     (lvl)
    );

    ocd_adjust_capture #(.WL_W(WL_W), .T_WR(T_WR)) u_adj (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (adj_start),
        .stop    (adj_stop),
        .wl      (wl),
        .adj_bit (adj_bit),
        .code    (adj_code),
        .valid   (adj_valid),
        .done    (adj_done)
    );

    // Fan the single drive level out to data and strobe pins.
    assign dq_oe    = oe;
    assign dqs_oe   = oe;
    assign dq_level = {DQ_W{lvl}};
    assign dqs_t    = lvl;
    assign dqs_c    = ~lvl;

    assert_no_err_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bl_err && cmd_err));

endmodule

// File: tb/sim_ocd_cal_handler.sv
// Directed bench for the calibration handler; each task checks its own scenario.
module sim_ocd_cal_handler;

    localparam int DQ_W  = 8;
    localparam int LAT_W = 3;
    localparam int TOIT  = 4;
    localparam int TWR   = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       cmd;
    logic [2:0]       ocd_sel;
    logic [LAT_W-1:0] al, cl;
    logic             bl4, adj_bit;
    logic             dq_oe, dqs_oe, dqs_t, dqs_c, adj_valid, bl_err, cmd_err;
    logic [DQ_W-1:0]  dq_level;
    logic [3:0]       adj_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ocd_cal_handler #(.DQ_W(DQ_W), .LAT_W(LAT_W), .T_OIT(TOIT), .T_WR(TWR)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ocd_sel(ocd_sel), .al(al), .cl(cl),
        .bl4(bl4), .adj_bit(adj_bit), .dq_oe(dq_oe), .dq_level(dq_level),
        .dqs_oe(dqs_oe), .dqs_t(dqs_t), .dqs_c(dqs_c), .adj_code(adj_code),
        .adj_valid(adj_valid), .bl_err(bl_err), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one command for one edge; caller sits at a falling edge.
    task automatic issue(input logic [1:0] c, input logic [2:0] s);
        cmd = c; ocd_sel = s;
        @(negedge clk);
        cmd = 2'b00; ocd_sel = 3'b000;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cmd = 2'b00; ocd_sel = 3'b000;
        al = '0; cl = 3'd3; bl4 = 1'b1; adj_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "oe in reset", {30'd0, dq_oe, dqs_oe}, 32'd0);
        chk("R1", "flags in reset", {29'd0, adj_valid, bl_err, cmd_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_drive(input bit hi);
        string r = hi ? "R2" : "R3";
        issue(2'b01, hi ? 3'b001 : 3'b100);
        chk(r, "cmd_err on enter", cmd_err, 0);
        repeat (TOIT - 1) @(negedge clk);
        chk(r, "oe before tOIT", {30'd0, dq_oe, dqs_oe}, 32'd0);
        @(negedge clk);
        chk(r, "oe at tOIT", {30'd0, dq_oe, dqs_oe}, 32'd3);
        chk(r, "dq levels", dq_level, hi ? {DQ_W{1'b1}} : '0);
        chk(r, "strobe pair", {30'd0, dqs_t, dqs_c}, hi ? 32'd2 : 32'd1);
    endtask

    task automatic t_exit_drive();
        issue(2'b01, 3'b000);
        chk("R4", "cmd_err on exit", cmd_err, 0);
        repeat (TOIT - 1) @(negedge clk);
        chk("R4", "oe before off", {30'd0, dq_oe, dqs_oe}, 32'd3);
        @(negedge clk);
        chk("R4", "oe after off", {30'd0, dq_oe, dqs_oe}, 32'd0);
    endtask

    task automatic t_stray_in_drive();
        issue(2'b10, 3'b000);
        chk("R8", "cmd_err on stray", cmd_err, 1);
        issue(2'b01, 3'b100);
        chk("R8", "cmd_err on re-enter", cmd_err, 1);
        repeat (TOIT + 1) @(negedge clk);
        chk("R8", "oe kept", {30'd0, dq_oe, dqs_oe}, 32'd3);
        chk("R8", "levels kept", {dq_level, dqs_t, dqs_c}, {{DQ_W{1'b1}}, 2'b10});
    endtask

    task automatic t_adjust(input int a, input int c, input logic [3:0] pat, input bit stray);
        int  wl = a + c - 1;
        bit  early = 0;
        al = LAT_W'(a); cl = LAT_W'(c); bl4 = 1'b1;
        issue(2'b01, 3'b010);
        chk("R5", "cmd_err on adjust", cmd_err, 0);
        for (int j = 1; j <= wl + 3; j++) begin
            adj_bit = (j >= wl) ? pat[j - wl] : ~pat[0];
            if (stray && j == wl + 3) cmd = 2'b11;
            @(negedge clk);
            cmd = 2'b00;
            if (j < wl + 3 && adj_valid) early = 1;
        end
        chk("R9", "no early valid", early, 0);
        chk("R5", "valid after beat 3", adj_valid, 1);
        chk("R5", "code order", adj_code, pat);
        if (stray) chk("R8", "stray at beat 3", cmd_err, 1);
        adj_bit = 1'b0;
        @(negedge clk);
        chk("R5", "valid one cycle", adj_valid, 0);
        repeat (TWR - 3) @(negedge clk);
        issue(2'b01, 3'b000);
        chk("R7", "early exit flagged", cmd_err, 1);
        issue(2'b01, 3'b000);
        chk("R7", "exit at tWR accepted", cmd_err, 0);
        t_drive(1);
        t_exit_drive();
    endtask

    task automatic t_bl_reject();
        bit seen = 0;
        al = '0; cl = 3'd3; bl4 = 1'b0;
        issue(2'b01, 3'b010);
        chk("R6", "bl_err pulse", bl_err, 1);
        @(negedge clk);
        chk("R6", "bl_err one cycle", bl_err, 0);
        for (int j = 0; j < 8; j++) begin
            adj_bit = j[0];
            @(negedge clk);
            if (adj_valid) seen = 1;
        end
        chk("R6", "no capture", seen, 0);
        bl4 = 1'b1;
        t_drive(1);
        t_exit_drive();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_drive(1);
        t_exit_drive();
        t_drive(0);
        t_exit_drive();
        t_drive(1);
        t_stray_in_drive();
        t_exit_drive();
        t_adjust(0, 3, 4'b1011, 0);
        t_adjust(2, 4, 4'b0110, 0);
        t_adjust(1, 1, 4'b1001, 1);
        t_bl_reject();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule